// File: doc/BRIEF.md
# Strobed FIFO with programmable almost flag

A first-in first-out store of 2048 words of 9 bits, written by a load strobe and read by an unload strobe. Both strobes are enables sampled on the rising edge of one shared clock. The head word is always on the output register. The first word stored into an empty buffer appears there at once, without an unload. Four status outputs report the fill level: active-low full, active-low empty, half-full, and one almost flag that is high near either end of the range.

The two almost thresholds are a low offset X and a high offset Y. Each is 10 bits wide: nine data bits plus a separate extra most significant bit input. They are captured from the data port during a short window after reset. The first load strobe taken with the program input low writes the same value into both X and Y. A second such strobe straight after it rewrites Y alone. A load strobe that captures an offset stores no data. The window shuts for good on the first load strobe taken with the program input high, or after the second capture, and only a reset opens it again. If nothing is captured, both offsets are 256.

An output enable gates the data bus only. The three-state pad is modelled as a zeroed bus plus a valid flag.

Top module: `strobe_fifo`

## Requirements
- R1: The store holds 2048 words. `full_n_o` is low exactly when the occupancy is 2048, and full and empty are never active together.
- R2: A load while full leaves the stored data and the occupancy unchanged. An unload while empty has no effect. `empty_n_o` is low exactly when the occupancy is 0.
- R3: `half_o` is high when the occupancy is 1024 or more, and low at 1023 or fewer.
- R4: `almost_o` is high when the occupancy is at most X or at least 2048 minus Y, and low otherwise.
- R5: With no programming after reset, X and Y are both 256.
- R6: The offset value is {`din_msb_i`, `din_i`}, so 1023 is the largest offset. The first load strobe after reset with `prog_n_i` low loads this value into X and Y. The next load strobe, if `prog_n_i` is still low, reloads Y only. Neither strobe stores a word.
- R7: The capture window closes on the first load strobe taken with `prog_n_i` high (that strobe stores a word) and after the second capture. Later strobes with `prog_n_i` low store words.
- R8: While `rst_n` is low and after it is released: `full_n_o` is 1, `empty_n_o` is 0, `half_o` is 0, `almost_o` is 1, and the offsets return to 256.
- R9: A word loaded into an empty buffer appears on `dout_o` one cycle later and `empty_n_o` rises, with no unload.
- R10: A load and an unload in the same cycle leave the occupancy unchanged when the buffer is neither empty nor full. When it is empty only the load acts, and when it is full only the unload acts.
- R11: After an unload, `dout_o` shows the next stored word. If the buffer has become empty, it keeps the last word.
- R12: With `oe_i` low, `dout_o` is zero and `dout_en_o` is low. The status outputs do not change.
- R13: Words leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Load strobe |
| ul_i | input | 1 | Unload strobe |
| din_i | input | 9 | Write data, also the low offset bits |
| din_msb_i | input | 1 | Extra offset most significant bit |
| prog_n_i | input | 1 | Active-low offset capture request |
| oe_i | input | 1 | Data output enable |
| dout_o | output | 9 | Head word, zero when disabled |
| dout_en_o | output | 1 | Data bus valid (pad drive) flag |
| full_n_o | output | 1 | Low when full |
| empty_n_o | output | 1 | Low when empty |
| half_o | output | 1 | High at half occupancy or more |
| almost_o | output | 1 | High near empty or near full |

## Verification
Every strobe acts at the rising edge where it is sampled. The occupancy, the flags and the head register all update at that edge, so each result is due exactly one cycle after the stimulus is applied. The bench drives inputs on the falling edge and compares 1 ns after the next rising edge against a reference model stepped at that same edge. The model holds a queue of expected words and its own offsets and occupancy. The threshold points X, X+1, 2048-Y-1 and 2048-Y are each crossed with default, separately programmed and maximum offsets.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  localparam int unsigned FIFO_DEPTH  = 2048;
  localparam int unsigned FIFO_DATA_W = 9;
  localparam int unsigned OFS_DEFAULT = 256;

  // almost band: low end up to x, high end from depth-y upward
  function automatic logic almost_hit(int unsigned occ, int unsigned x,
                                      int unsigned y, int unsigned depth);
    return (occ <= x) || (occ + y >= depth);
  endfunction

  function automatic logic half_hit(int unsigned occ, int unsigned depth);
    return occ >= depth / 2;
  endfunction
endpackage

// File: rtl/fifo_thresh.sv
module fifo_thresh #(
  parameter int unsigned OFS_W   = 10,
  parameter int unsigned DEF_OFS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             prog_n,
  input  logic [OFS_W-1:0] val,
  output logic             cap,
  output logic [OFS_W-1:0] x_ofs,
  output logic [OFS_W-1:0] y_ofs
);
  logic open_q, second_q;

  assign cap = ld && open_q && !prog_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b1;
      second_q <= 1'b0;
      x_ofs    <= OFS_W'(DEF_OFS);
      y_ofs    <= OFS_W'(DEF_OFS);
    end else if (ld && open_q) begin
      if (!prog_n) begin
        if (!second_q) begin
          x_ofs    <= val;
          y_ofs    <= val;
          second_q <= 1'b1;
        end else begin
          y_ofs  <= val;
          open_q <= 1'b0;
        end
      end else begin
        open_q <= 1'b0;
      end
    end
  end

  p_closed_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |=> ($stable(x_ofs) && $stable(y_ofs)));
  p_first_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !second_q) |=> (x_ofs == y_ofs));
endmodule

// File: rtl/fifo_occ.sv
module fifo_occ
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned OFS_W = 10,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic             rd_go,
  input  logic [OFS_W-1:0] x_ofs,
  input  logic [OFS_W-1:0] y_ofs,
  output logic [CNT_W-1:0] occ,
  output logic             full_n,
  output logic             empty_n,
  output logic             half,
  output logic             almost
);
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else begin
      case ({wr_go, rd_go})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full_n  = (occ != CNT_W'(DEPTH));
  assign empty_n = (occ != '0);
  assign half    = half_hit(32'(occ), DEPTH);
  assign almost  = almost_hit(32'(occ), 32'(x_ofs), 32'(y_ofs), DEPTH);

  p_occ_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rd_go) |=> (occ == $past(occ)));
  p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  occ,
  output logic [DATA_W-1:0] head
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [ADDR_W-1:0] rd_nxt;
  logic              load_head_din, load_head_mem;

  assign rd_nxt        = rd_ptr + 1'b1;
  assign load_head_din = wr_go && ((occ == '0) || (occ == CNT_W'(1) && rd_go));
  assign load_head_mem = rd_go && (occ > CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_go) wr_ptr <= wr_ptr + 1'b1;
      if (rd_go) rd_ptr <= rd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_ptr] <= din;
  end

  // head is deliberately not reset
  always_ff @(posedge clk) begin
    if (load_head_din)      head <= din;
    else if (load_head_mem) head <= mem[rd_nxt];
  end

  p_fallthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && occ == '0) |=> (head == $past(din)));
  p_hold_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !wr_go && occ == CNT_W'(1)) |=> $stable(head));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = FIFO_DATA_W,
  parameter int unsigned DEPTH  = FIFO_DEPTH,
  parameter int unsigned DEF_OFS = OFS_DEFAULT,
  localparam int unsigned OFS_W = DATA_W + 1,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic              ul_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              din_msb_i,
  input  logic              prog_n_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o,
  output logic              full_n_o,
  output logic              empty_n_o,
  output logic              half_o,
  output logic              almost_o
);
  logic             cap;
  logic [OFS_W-1:0] x_ofs, y_ofs;
  logic [CNT_W-1:0] occ;
  logic             wr_go, rd_go;
  logic [DATA_W-1:0] head;

  fifo_thresh #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_thresh (
    .clk(clk), .rst_n(rst_n), .ld(ld_i), .prog_n(prog_n_i),
    .val({din_msb_i, din_i}), .cap(cap), .x_ofs(x_ofs), .y_ofs(y_ofs)
  );

  assign wr_go = ld_i && !cap && full_n_o;
  assign rd_go = ul_i && empty_n_o;

  fifo_occ #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
    .x_ofs(x_ofs), .y_ofs(y_ofs), .occ(occ), .full_n(full_n_o),
    .empty_n(empty_n_o), .half(half_o), .almost(almost_o)
  );

  fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
    .din(din_i), .occ(occ), .head(head)
  );

  assign dout_o    = oe_i ? head : '0;
  assign dout_en_o = oe_i;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n_o && ld_i && !ul_i) |=> !full_n_o);
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n_o && ul_i && !ld_i) |=> !empty_n_o);
  p_not_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n_o && !empty_n_o));
  p_full_almost_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n_o || !empty_n_o) |-> almost_o);
  p_full_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n_o |-> half_o);
  p_cap_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !ul_i) |=> $stable(occ));
endmodule

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b0, ul = 1'b0, msb = 1'b0, prog_n = 1'b1, oe = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_en, full_n, empty_n, half, almost;

  int nchk = 0, nerr = 0;
  int mcnt, mx, my;
  bit mopen, msecond;
  logic [8:0] q[$];
  logic [8:0] last_out;

  always #2 clk = ~clk;

  strobe_fifo dut (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ul_i(ul), .din_i(din),
    .din_msb_i(msb), .prog_n_i(prog_n), .oe_i(oe), .dout_o(dout),
    .dout_en_o(dout_en), .full_n_o(full_n), .empty_n_o(empty_n),
    .half_o(half), .almost_o(almost)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_almost();
    return (mcnt <= mx) || (mcnt >= DEPTH - my);
  endfunction

  task automatic flag_checks();
    chk(full_n == (mcnt != DEPTH), "R1 full_n", int'(full_n), int'(mcnt != DEPTH));
    chk(empty_n == (mcnt != 0), "R2 empty_n", int'(empty_n), int'(mcnt != 0));
    chk(half == (mcnt >= DEPTH / 2), "R3 half", int'(half), int'(mcnt >= DEPTH / 2));
    chk(almost == exp_almost(), "R4 almost", int'(almost), int'(exp_almost()));
  endtask

  // driver: applies one cycle, updates the scoreboard at the edge, then compares
  task automatic step(input logic l, input logic u, input logic [8:0] d,
                      input logic m, input logic pn);
    bit cap, wr, rd;
    @(negedge clk);
    ld = l; ul = u; din = d; msb = m; prog_n = pn;
    @(posedge clk);
    cap = l && mopen && !pn;
    if (l && mopen) begin
      if (!pn) begin
        if (!msecond) begin mx = {m, d}; my = {m, d}; msecond = 1; end
        else begin my = {m, d}; mopen = 0; end
      end else mopen = 0;
    end
    wr = l && !cap && (mcnt < DEPTH);
    rd = u && (mcnt > 0);
    if (rd) begin last_out = q.pop_front(); mcnt--; end
    if (wr) begin q.push_back(d); mcnt++; end
    #1;
    flag_checks();
    if (oe && mcnt > 0) chk(dout == q[0], "R13 head word", int'(dout), int'(q[0]));
    @(negedge clk);
    ld = 0; ul = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ld = 0; ul = 0; prog_n = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mcnt = 0; mx = 256; my = 256; mopen = 1; msecond = 0;
    q.delete();
    #0;
    chk(full_n == 1, "R8 reset full_n", int'(full_n), 1);
    chk(empty_n == 0, "R8 reset empty_n", int'(empty_n), 0);
    chk(half == 0, "R8 reset half", int'(half), 0);
    chk(almost == 1, "R8 reset almost", int'(almost), 1);
  endtask

  task automatic fill_to(input int target);
    while (mcnt < target) step(1, 0, 9'((mcnt * 37 + 5) & 9'h1ff), 0, 1);
  endtask

  task automatic drain_to(input int target);
    while (mcnt > target) step(0, 1, 9'h0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    // default offsets, full range
    do_reset();
    step(1, 0, 9'h0a5, 0, 1);
    chk(empty_n == 1 && dout == 9'h0a5, "R9 fall-through", int'(dout), 'h0a5);
    fill_to(256);
    chk(almost == 1, "R5 default X at 256", int'(almost), 1);
    fill_to(257);
    chk(almost == 0, "R5 default X+1", int'(almost), 0);
    fill_to(1791);
    chk(almost == 0, "R5 default 2048-Y-1", int'(almost), 0);
    fill_to(1792);
    chk(almost == 1, "R5 default 2048-Y", int'(almost), 1);
    fill_to(DEPTH);
    step(1, 0, 9'h1ff, 0, 1);
    chk(full_n == 0, "R2 load while full ignored", int'(full_n), 0);
    step(1, 1, 9'h1fe, 0, 1);
    chk(full_n == 1, "R10 full: only unload acts", int'(full_n), 1);
    step(1, 1, 9'h0c3, 0, 1);
    chk(full_n == 1, "R10 mid: occupancy held", int'(full_n), 1);
    drain_to(0);
    chk(dout == last_out, "R11 hold last word when empty", int'(dout), int'(last_out));
    step(0, 1, 9'h0, 0, 1);
    chk(empty_n == 0 && dout == last_out, "R2 unload while empty", int'(dout), int'(last_out));
    step(1, 1, 9'h13c, 0, 1);
    chk(empty_n == 1 && dout == 9'h13c, "R10 empty: only load acts", int'(dout), 'h13c);
    step(1, 0, 9'h022, 0, 1);
    step(0, 1, 9'h0, 0, 1);
    chk(dout == 9'h022, "R11 next word after unload", int'(dout), 'h022);
    oe = 0;
    step(1, 0, 9'h055, 0, 1);
    #1;
    chk(dout == 0 && dout_en == 0, "R12 bus gated", int'(dout), 0);
    chk(empty_n == 1, "R12 flags unaffected", int'(empty_n), 1);
    oe = 1;
    step(0, 0, 9'h0, 0, 1);

    // separate X and Y programming
    do_reset();
    step(1, 0, 9'd5, 0, 0);
    chk(empty_n == 0, "R6 capture stores no word", int'(empty_n), 0);
    step(1, 0, 9'd3, 1, 0);
    chk(empty_n == 0, "R6 second capture stores no word", int'(empty_n), 0);
    step(1, 0, 9'd7, 0, 0);
    chk(empty_n == 1, "R7 window closed after two captures", int'(empty_n), 1);
    fill_to(5);
    chk(almost == 1, "R6 X=5 at 5", int'(almost), 1);
    fill_to(6);
    chk(almost == 0, "R6 X=5 at 6", int'(almost), 0);
    fill_to(1532);
    chk(almost == 0, "R6 Y=515 at 1532", int'(almost), 0);
    fill_to(1533);
    chk(almost == 1, "R6 Y=515 at 1533", int'(almost), 1);
    drain_to(0);

    // one capture then a plain load closes the window
    do_reset();
    step(1, 0, 9'd10, 0, 0);
    step(1, 0, 9'h111, 0, 1);
    step(1, 0, 9'd2, 0, 0);
    chk(empty_n == 1 && dout == 9'h111, "R7 closed by plain load", int'(dout), 'h111);
    fill_to(10);
    chk(almost == 1, "R6 shared X=10", int'(almost), 1);
    fill_to(11);
    chk(almost == 0, "R6 shared X+1", int'(almost), 0);
    drain_to(0);

    // plain load first: window never opens for capture
    do_reset();
    step(1, 0, 9'h0f0, 0, 1);
    step(1, 0, 9'd1, 0, 0);
    fill_to(256);
    chk(almost == 1, "R7 offsets stay default", int'(almost), 1);
    drain_to(0);

    // maximum offsets
    do_reset();
    step(1, 0, 9'h1ff, 1, 0);
    step(1, 0, 9'h100, 0, 1);
    fill_to(1023);
    chk(almost == 1, "R6 X=1023 at 1023", int'(almost), 1);
    fill_to(1024);
    chk(almost == 0, "R6 max at 1024", int'(almost), 0);
    fill_to(1025);
    chk(almost == 1, "R6 Y=1023 at 1025", int'(almost), 1);

    // reset mid-stream
    do_reset();
    step(0, 0, 9'h0, 0, 1);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule